// File: doc/BRIEF.md
# Float-to-Integer Store Converter

This block turns an 80-bit extended-precision floating-point operand into a signed two's-complement integer of 16, 32 or 64 bits. The conversion follows a 2-bit rounding-mode input and does not simply truncate. It sits behind the register stack of a floating-point unit. The unit hands it the value and the destination width together with a one-cycle strobe. Two clock edges later the block returns the integer and two flags: one for an invalid operation and one for an inexact result. The memory write that follows is not part of this block.

The operand holds one sign bit in bit 79 and a 15-bit biased exponent in bits 78:64, with a bias of 16383. Bits 63:0 hold a 64-bit significand whose integer bit is explicit.

Several cases give an invalid operation: infinity, NaN, and any value whose rounded magnitude does not fit the chosen width. In each of these the block returns the integer-indefinite pattern, which is the most negative integer of that width. The result always fills all 64 output bits, sign-extended from the selected width.

Top module: `f2i_store_conv`

## Requirements
- R1: A result appears with `out_vld` high exactly two rising edges after the edge that samples `in_vld` high. `out_vld` is high only in response to such a strobe.
- R2: Both +0 and -0 give integer 0 with neither flag raised.
- R3: Rounding mode 00 rounds to nearest, with ties to the even integer (2.5 gives 2, -2.5 gives -2, 0.5 gives 0).
- R4: Rounding mode 01 rounds toward minus infinity, mode 10 toward plus infinity and mode 11 toward zero.
- R5: A nonzero value of magnitude below 1, including an operand with exponent field 0, gives 0 or +1 when positive and 0 or -1 when negative, as the rounding mode decides.
- R6: An exponent field of all ones (infinity or NaN) always gives an invalid result, for every width.
- R7: The range check is applied after rounding. A value that rounds to 2^(N-1) is invalid. -2^(N-1) is accepted without any flag.
- R8: On an invalid result, `out_int` is the most negative N-bit integer sign-extended to 64 bits, and `out_invalid` is high.
- R9: `out_inexact` is high exactly when a discarded fraction bit is nonzero and the result is not invalid.
- R10: `in_width` encodes 00 as 16 bits, 01 as 32 bits, and both 10 and 11 as 64 bits. A valid result is the N-bit integer sign-extended to 64 bits.
- R11: While `rst_n` is low, and after reset until a new strobe has passed through, `out_vld`, `out_invalid` and `out_inexact` are low. A strobe seen during reset is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Operand strobe |
| in_op | input | 80 | Extended-precision operand |
| in_width | input | 2 | Destination width select |
| in_rmode | input | 2 | Rounding mode |
| out_vld | output | 1 | Result strobe |
| out_int | output | 64 | Integer result, sign-extended |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Precision flag |

## Verification
The hardest cases to reach are those in which rounding itself moves a value across the range limit. One example is 32767.5 rounded to nearest into 16 bits: it carries into 32768, which must then be reported invalid. The same operand rounded toward zero must instead stay valid and inexact. The stimulus table builds these operands directly from exponent and significand patterns, with the tie bit placed just below the integer boundary. Each operand is paired with the modes and widths that put it on either side of the limit. The most negative value of each width is also applied, so that the asymmetry between the negative and positive limits is exercised.

// File: rtl/f2i_pkg.sv
// Package: shared encodings for the float-to-integer store converter.
// Assumes: operand layout sign | biased exponent | explicit-integer significand.
package f2i_pkg;

    // Rounding mode encoding on the in_rmode pins.
    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_DOWN    = 2'b01,
        RM_UP      = 2'b10,
        RM_ZERO    = 2'b11
    } rmode_e;

    // Destination width encoding; the last code aliases the widest format.
    typedef enum logic [1:0] {
        DW_16  = 2'b00,
        DW_32  = 2'b01,
        DW_64  = 2'b10,
        DW_64B = 2'b11
    } dwidth_e;

endpackage

// File: rtl/f2i_align.sv
// Module: f2i_align
// Unpacks the operand and right-aligns the significand so that the integer
// part, the first discarded bit (round) and the OR of the rest (sticky) are
// separated. Flags operands that no destination width can hold (all-ones
// exponent, or magnitude of at least 2^SIG_W). Registers its outputs.
// Assumes: SIG_W equals the widest integer width; exponent bias 2^(EXP_W-1)-1.
module f2i_align #(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   i_vld,
    input  logic [EXP_W+SIG_W:0]   i_op,
    input  logic [1:0]             i_wsel,
    input  logic [1:0]             i_mode,
    output logic                   a_vld,
    output logic                   a_sign,
    output logic                   a_big,
    output logic [SIG_W-1:0]       a_mag,
    output logic                   a_rnd,
    output logic                   a_stk,
    output logic [1:0]             a_wsel,
    output logic [1:0]             a_mode
);
    localparam int BIAS  = (2 ** (EXP_W - 1)) - 1;
    localparam int UEXPW = EXP_W + 2;
    localparam int SH_W  = $clog2(SIG_W) + 1;

    logic [EXP_W-1:0]        exp_f;
    logic [SIG_W-1:0]        sig_f;
    logic                    sgn_f;
    logic signed [UEXPW-1:0] e_unb;
    logic [SH_W-1:0]         shamt;
    logic [2*SIG_W-1:0]      wide;
    logic                    big_c, rnd_c, stk_c;
    logic [SIG_W-1:0]        mag_c;

    // Field extraction and unbiased exponent.
    always_comb begin
        sgn_f = i_op[EXP_W+SIG_W];
        exp_f = i_op[SIG_W +: EXP_W];
        sig_f = i_op[SIG_W-1:0];
        e_unb = $signed({2'b00, exp_f}) - $signed(UEXPW'(BIAS));
    end

    // Alignment: split significand into integer part, round bit and sticky.
    always_comb begin
        big_c = 1'b0;
        mag_c = '0;
        rnd_c = 1'b0;
        stk_c = 1'b0;
        shamt = '0;
        wide  = '0;
        if ((&exp_f) || (e_unb >= $signed(UEXPW'(SIG_W)))) begin
            big_c = 1'b1;
        end else if (e_unb >= 0) begin
            shamt = SH_W'(SIG_W - 1) - SH_W'(e_unb);
            wide  = {sig_f, {SIG_W{1'b0}}} >> shamt;
            mag_c = wide[2*SIG_W-1:SIG_W];
            rnd_c = wide[SIG_W-1];
            stk_c = |wide[SIG_W-2:0];
        end else if (e_unb == -1) begin
            rnd_c = sig_f[SIG_W-1];
            stk_c = |sig_f[SIG_W-2:0];
        end else begin
            stk_c = |sig_f;
        end
    end

    // Stage register; strobe cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_vld <= 1'b0;
        end else begin
            a_vld <= i_vld;
        end
        a_sign <= sgn_f;
        a_big  <= big_c;
        a_mag  <= mag_c;
        a_rnd  <= rnd_c;
        a_stk  <= stk_c;
        a_wsel <= i_wsel;
        a_mode <= i_mode;
    end

    // R6: an all-ones exponent must reach the next stage marked unrepresentable.
    p_special_big_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (i_vld && (&i_op[SIG_W +: EXP_W])) |=> a_big);

endmodule

// File: rtl/f2i_round.sv
// Module: f2i_round
// Applies the rounding increment for the selected mode, checks the rounded
// magnitude against every destination width in parallel, selects the width's
// result or its integer-indefinite pattern, and registers result and flags.
// Assumes: BASE_W << (NUM_W-1) <= INT_W; widths double from BASE_W upward.
module f2i_round #(
    parameter int INT_W  = 64,
    parameter int BASE_W = 16,
    parameter int NUM_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_vld,
    input  logic             i_sign,
    input  logic             i_big,
    input  logic [INT_W-1:0] i_mag,
    input  logic             i_rnd,
    input  logic             i_stk,
    input  logic [1:0]       i_wsel,
    input  logic [1:0]       i_mode,
    output logic             o_vld,
    output logic [INT_W-1:0] o_int,
    output logic             o_inv,
    output logic             o_inx
);
    import f2i_pkg::*;

    localparam int IDX_W = (NUM_W > 1) ? $clog2(NUM_W) : 1;

    logic             inc;
    logic [INT_W:0]   mag_r;
    logic [NUM_W-1:0] ovf_w;
    logic [INT_W-1:0] indef_w [NUM_W];
    logic [IDX_W-1:0] idx;
    logic             inv_c;
    logic [INT_W-1:0] res_c;

    // Rounding increment from mode, sign, round and sticky bits.
    always_comb begin
        unique case (rmode_e'(i_mode))
            RM_NEAREST: inc = i_rnd & (i_stk | i_mag[0]);
            RM_DOWN:    inc = i_sign & (i_rnd | i_stk);
            RM_UP:      inc = ~i_sign & (i_rnd | i_stk);
            default:    inc = 1'b0;
        endcase
        mag_r = {1'b0, i_mag} + {{INT_W{1'b0}}, inc};
    end

    // Per-width range limits and indefinite patterns.
    for (genvar g = 0; g < NUM_W; g++) begin : g_width
        localparam int WB = BASE_W << g;
        localparam logic [INT_W:0] LIM = (INT_W+1)'(1) << (WB - 1);
        assign ovf_w[g]   = i_sign ? (mag_r > LIM) : (mag_r >= LIM);
        assign indef_w[g] = {INT_W{1'b1}} << (WB - 1);
    end

    // Width index; codes beyond the last width alias the widest.
    always_comb begin
        if (int'(i_wsel) >= NUM_W) idx = IDX_W'(NUM_W - 1);
        else                       idx = IDX_W'(i_wsel);
    end

    // Result selection: indefinite on invalid, else signed rounded magnitude.
    always_comb begin
        inv_c = i_big | ovf_w[idx];
        if (inv_c)       res_c = indef_w[idx];
        else if (i_sign) res_c = -mag_r[INT_W-1:0];
        else             res_c = mag_r[INT_W-1:0];
    end

    // Output register; flags qualified by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_vld <= 1'b0;
            o_inv <= 1'b0;
            o_inx <= 1'b0;
        end else begin
            o_vld <= i_vld;
            o_inv <= i_vld & inv_c;
            o_inx <= i_vld & ~inv_c & (i_rnd | i_stk);
        end
        o_int <= res_c;
    end

    // R9: the two flags are never raised together.
    p_inexact_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(o_inv && o_inx));

    // R11: flags only accompany a result strobe.
    p_flags_need_vld_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (o_inv || o_inx) |-> o_vld);

    // R10: a valid 16-bit result is sign-extended through the upper bits.
    p_sext16_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (i_vld && !inv_c && i_wsel == DW_16) |=>
        ($countones(o_int[INT_W-1:BASE_W-1]) == 0 ||
         $countones(o_int[INT_W-1:BASE_W-1]) == INT_W - BASE_W + 1));

    // R8: an invalid result carries a negative pattern with zero low bits.
    p_indef_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
        o_inv |-> (o_int[INT_W-1] && o_int[BASE_W-2:0] == '0));

endmodule

// File: rtl/f2i_store_conv.sv
// Module: f2i_store_conv (top)
// Two-stage float-to-integer converter: alignment stage, then rounding and
// range-check stage. Latency two edges, one operand per cycle.
// Assumes: significand width equals the widest integer width.
module f2i_store_conv #(
    parameter int EXP_W  = 15,
    parameter int SIG_W  = 64,
    parameter int BASE_W = 16,
    parameter int NUM_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [EXP_W+SIG_W:0] in_op,
    input  logic [1:0]           in_width,
    input  logic [1:0]           in_rmode,
    output logic                 out_vld,
    output logic [SIG_W-1:0]     out_int,
    output logic                 out_invalid,
    output logic                 out_inexact
);
    logic             a_vld, a_sign, a_big, a_rnd, a_stk;
    logic [SIG_W-1:0] a_mag;
    logic [1:0]       a_wsel, a_mode;

    f2i_align #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_align (
        .clk(clk), .rst_n(rst_n), .i_vld(in_vld), .i_op(in_op),
        .i_wsel(in_width), .i_mode(in_rmode),
        .a_vld(a_vld), .a_sign(a_sign), .a_big(a_big), .a_mag(a_mag),
        .a_rnd(a_rnd), .a_stk(a_stk), .a_wsel(a_wsel), .a_mode(a_mode)
    );

    f2i_round #(.INT_W(SIG_W), .BASE_W(BASE_W), .NUM_W(NUM_W)) u_round (
        .clk(clk), .rst_n(rst_n), .i_vld(a_vld), .i_sign(a_sign),
        .i_big(a_big), .i_mag(a_mag), .i_rnd(a_rnd), .i_stk(a_stk),
        .i_wsel(a_wsel), .i_mode(a_mode),
        .o_vld(out_vld), .o_int(out_int), .o_inv(out_invalid), .o_inx(out_inexact)
    );

    // R1: the result strobe follows the internal stage strobe by one edge.
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == $past(a_vld));

endmodule

// File: tb/f2i_store_conv_bench.sv
`timescale 1ns/1ps
module f2i_store_conv_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [79:0] in_op = '0;
    logic [1:0]  in_width = '0;
    logic [1:0]  in_rmode = '0;
    logic        out_vld, out_invalid, out_inexact;
    logic [63:0] out_int;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    f2i_store_conv u_f2i_store_conv (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
        .in_width(in_width), .in_rmode(in_rmode), .out_vld(out_vld),
        .out_int(out_int), .out_invalid(out_invalid), .out_inexact(out_inexact)
    );

    // Vector: operand, width, mode, expected integer, invalid, inexact, tag.
    localparam int NV = 29;
    localparam logic [149:0] VEC [NV] = '{
        {80'h0000_0000000000000000, 2'd0, 2'd0, 64'h0, 1'b0, 1'b0},              // R2 +0
        {80'h8000_0000000000000000, 2'd1, 2'd3, 64'h0, 1'b0, 1'b0},              // R2 -0
        {80'h3FFF_C000000000000000, 2'd1, 2'd0, 64'h2, 1'b0, 1'b1},              // R3 1.5
        {80'h4000_A000000000000000, 2'd1, 2'd0, 64'h2, 1'b0, 1'b1},              // R3 2.5 tie
        {80'hC000_A000000000000000, 2'd1, 2'd0, 64'hFFFFFFFFFFFFFFFE, 1'b0, 1'b1}, // R3 -2.5
        {80'h3FFF_C000000000000000, 2'd1, 2'd3, 64'h1, 1'b0, 1'b1},              // R4 zero
        {80'hBFFF_C000000000000000, 2'd1, 2'd1, 64'hFFFFFFFFFFFFFFFE, 1'b0, 1'b1}, // R4 down
        {80'hBFFF_C000000000000000, 2'd1, 2'd2, 64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b1}, // R4 up
        {80'h3FFD_8000000000000000, 2'd0, 2'd2, 64'h1, 1'b0, 1'b1},              // R5 0.25 up
        {80'h3FFD_8000000000000000, 2'd0, 2'd0, 64'h0, 1'b0, 1'b1},              // R5 0.25 near
        {80'hBFFD_8000000000000000, 2'd0, 2'd1, 64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b1}, // R5 -0.25 down
        {80'hBFFD_8000000000000000, 2'd0, 2'd3, 64'h0, 1'b0, 1'b1},              // R5 -0.25 zero
        {80'h3FFE_8000000000000000, 2'd0, 2'd0, 64'h0, 1'b0, 1'b1},              // R3 0.5 tie
        {80'h7FFF_8000000000000000, 2'd0, 2'd0, 64'hFFFFFFFFFFFF8000, 1'b1, 1'b0}, // R6 +inf
        {80'h7FFF_C000000000000000, 2'd2, 2'd0, 64'h8000000000000000, 1'b1, 1'b0}, // R6 NaN
        {80'h400D_FFFE000000000000, 2'd0, 2'd0, 64'h7FFF, 1'b0, 1'b0},           // R7 max16
        {80'h400D_FFFF000000000000, 2'd0, 2'd0, 64'hFFFFFFFFFFFF8000, 1'b1, 1'b0}, // R7 rounds out
        {80'h400D_FFFF000000000000, 2'd0, 2'd3, 64'h7FFF, 1'b0, 1'b1},           // R7 stays in
        {80'hC00E_8000000000000000, 2'd0, 2'd0, 64'hFFFFFFFFFFFF8000, 1'b0, 1'b0}, // R7 min16
        {80'h400E_8000000000000000, 2'd0, 2'd0, 64'hFFFFFFFFFFFF8000, 1'b1, 1'b0}, // R8 32768/16
        {80'h400E_8000000000000000, 2'd1, 2'd0, 64'h8000, 1'b0, 1'b0},           // R10 32768/32
        {80'h401E_8000000000000000, 2'd1, 2'd0, 64'hFFFFFFFF80000000, 1'b1, 1'b0}, // R8 2^31/32
        {80'h401E_8000000000000000, 2'd2, 2'd0, 64'h80000000, 1'b0, 1'b0},       // R10 2^31/64
        {80'h403E_8000000000000000, 2'd2, 2'd0, 64'h8000000000000000, 1'b1, 1'b0}, // R7 2^63
        {80'hC03E_8000000000000000, 2'd3, 2'd0, 64'h8000000000000000, 1'b0, 1'b0}, // R10 code 11
        {80'h3FFF_8000000000000000, 2'd0, 2'd1, 64'h1, 1'b0, 1'b0},              // R9 exact
        {80'h4063_8000000000000000, 2'd2, 2'd3, 64'h8000000000000000, 1'b1, 1'b0}, // R8 huge
        {80'hBFFF_C000000000000000, 2'd0, 2'd0, 64'hFFFFFFFFFFFFFFFE, 1'b0, 1'b1}, // R10 -2/16
        {80'h0000_0000000000000001, 2'd0, 2'd2, 64'h1, 1'b0, 1'b1}               // R5 tiny up
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic apply(input logic [79:0] op, input logic [1:0] w, input logic [1:0] m);
        @(negedge clk);
        in_op = op; in_width = w; in_rmode = m; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        chk("R1 early strobe", 64'(out_vld), 64'h0);
        @(negedge clk);
    endtask

    initial begin
        #200000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R11: strobe during reset is dropped; outputs low.
        in_vld = 1'b1; in_op = 80'h7FFF_8000000000000000;
        repeat (3) @(negedge clk);
        chk("R11 vld in reset", 64'(out_vld), 64'h0);
        chk("R11 flags in reset", 64'({out_invalid, out_inexact}), 64'h0);
        in_vld = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 vld after reset", 64'(out_vld), 64'h0);
        chk("R11 flags after reset", 64'({out_invalid, out_inexact}), 64'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][149:70], VEC[i][69:68], VEC[i][67:66]);
            chk("R1 result strobe", 64'(out_vld), 64'h1);
            chk("R2-R10 integer", out_int, VEC[i][65:2]);
            chk("R6/R7/R8 invalid", 64'(out_invalid), 64'(VEC[i][1]));
            chk("R9 inexact", 64'(out_inexact), 64'(VEC[i][0]));
            @(negedge clk);
            chk("R1 single strobe", 64'(out_vld), 64'h0);
        end

        // R1: back-to-back operands give back-to-back results.
        @(negedge clk);
        in_vld = 1'b1; in_op = 80'h4000_A000000000000000; in_width = 2'd1; in_rmode = 2'd2;
        @(negedge clk);
        in_op = 80'hC000_A000000000000000; in_rmode = 2'd3;
        @(negedge clk);
        in_vld = 1'b0;
        chk("R1 first of pair", out_int, 64'h3);   // R4 2.5 up -> 3
        chk("R1 first strobe", 64'(out_vld), 64'h1);
        @(negedge clk);
        chk("R1 second of pair", out_int, 64'hFFFFFFFFFFFFFFFE); // R4 -2.5 zero -> -2
        chk("R1 second strobe", 64'(out_vld), 64'h1);
        @(negedge clk);
        chk("R1 pair ends", 64'(out_vld), 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule